// File: doc/BRIEF.md
# Retimed Clock Divider with Sampling Phase Detector

This block is the digital front end of a clock-locking loop. A fast oscillator clock is divided by a fixed even ratio (1944 by default, which turns 155.52 MHz into an 80 kHz comparison rate). The divider's raw output is then retimed by a flop clocked by that same fast clock. As a result the divided clock changes only on fast-clock edges, and the counter's delay and jitter never reach it. The counter path only has to meet setup and hold at that retiming flop.

A slower reference clock (10 MHz in the intended loop) samples the retimed divided clock. That flop is a one-bit early/late detector. A second reference-domain flop filters metastability before the bit goes on to the external loop filter. A registered strobe marks every change of the filtered bit, so downstream logic can count early and late events.

The asynchronous active-low reset is synchronized separately into each clock domain. It takes effect at once and is released on a clock edge of that domain.

Top module: `lockdiv_frontend`

## Requirements
- R1: While `rst_n` is low, `div_clk_o`, `phase_err_o` and `phase_chg_o` are all 0 from the first edge of their own clock onward.
- R2: After `rst_n` rises between fast-clock edges, `div_clk_o` is 0 after the first and second rising fast-clock edges and becomes 1 after the third.
- R3: Once running, successive rising edges of `div_clk_o` are exactly DIV_RATIO fast-clock cycles apart.
- R4: `div_clk_o` stays high for exactly DIV_RATIO/2 fast-clock cycles of each period, which gives a 50% duty cycle.
- R5: `phase_err_o` shows the level of `div_clk_o` sampled at a rising reference edge, two rising reference edges later. It still holds the previous value after the first of those edges.
- R6: `phase_chg_o` is 1 for exactly the one reference cycle in which `phase_err_o` takes a new value, and 0 in every other cycle.
- R7: With both clocks at the same rate, `phase_err_o` is 1 (reference late) when the reference edge lands in the half period after a rising edge of `div_clk_o`. It is 0 (reference early) when the reference edge lands in the half period before one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Undivided oscillator clock; clocks the divider and the retiming flop |
| clk_ref | input | 1 | Reference clock; clocks the detector and metastability flops |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously per domain |
| div_clk_o | output | 1 | Divided clock, retimed to the fast clock |
| phase_err_o | output | 1 | Filtered early/late bit, 1 when the reference lags |
| phase_chg_o | output | 1 | One-reference-cycle strobe on each change of `phase_err_o` |

## Verification
If the divide counter skips or repeats a state, or wraps at the wrong count, `div_clk_o` shows it within one divided period. A rising-to-rising spacing other than the ratio, or a high time other than half of it, is visible at the next edge. A wrong retiming or release stage moves the first rising edge off the third fast cycle after reset. In the reference domain, a dropped or extra pipeline stage makes `phase_err_o` disagree with the sampled divided level two reference edges later. A stale change detector either shows a strobe without a change in the error bit or misses one in the very cycle the bit flips.

// File: rtl/lockdiv_pkg.sv
`timescale 1ns/1ps
package lockdiv_pkg;

    // Default division ratio: 155.52 MHz down to an 80 kHz comparison rate.
    localparam int unsigned DEF_DIV_RATIO   = 1944;
    // Depth of each per-domain reset release chain.
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Meaning of the filtered detector bit.
    typedef enum logic {
        PHASE_REF_EARLY = 1'b0,
        PHASE_REF_LATE  = 1'b1
    } phase_dir_e;

    // Reference-domain pipeline: detector flop, filter flop, change strobe.
    typedef struct packed {
        logic capture;
        logic settled;
        logic changed;
    } ref_pipe_t;

    // High for the first half of the count range.
    function automatic logic in_high_half(input int unsigned count,
                                          input int unsigned ratio);
        return count < (ratio / 2);
    endfunction

endpackage

// File: rtl/lockdiv_rst_sync.sv
`timescale 1ns/1ps
module lockdiv_rst_sync #(
    parameter int unsigned STAGES = lockdiv_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_o
);
    logic [STAGES-1:0] chain;

    // Asserts immediately, releases after STAGES edges of clk.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= '0;
        else         chain <= {chain[STAGES-2:0], 1'b1};
    end

    assign rst_o = ~chain[STAGES-1];
endmodule

// File: rtl/lockdiv_counter.sv
`timescale 1ns/1ps
module lockdiv_counter
    import lockdiv_pkg::*;
#(
    parameter int unsigned DIV_RATIO = DEF_DIV_RATIO
) (
    input  logic clk,
    input  logic rst,
    output logic raw_o
);
    localparam int unsigned CNT_W = $clog2(DIV_RATIO);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);

    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst)                 count <= '0;
        else if (count == LAST)  count <= '0;
        else                     count <= count + 1'b1;
    end

    // Combinational, may glitch; only the retiming flop may see it.
    assign raw_o = in_high_half(32'(count), DIV_RATIO);
endmodule

// File: rtl/lockdiv_retime.sv
`timescale 1ns/1ps
module lockdiv_retime (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst) q_o <= 1'b0;
        else     q_o <= d_i;
    end
endmodule

// File: rtl/lockdiv_phase_sampler.sv
`timescale 1ns/1ps
module lockdiv_phase_sampler
    import lockdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic err_o,
    output logic chg_o
);
    ref_pipe_t  pipe;
    phase_dir_e dir;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe.capture <= d_i;
            pipe.settled <= pipe.capture;
            pipe.changed <= pipe.capture ^ pipe.settled;
        end
    end

    assign dir   = phase_dir_e'(pipe.settled);
    assign err_o = (dir == PHASE_REF_LATE);
    assign chg_o = pipe.changed;
endmodule

// File: rtl/lockdiv_frontend.sv
`timescale 1ns/1ps
module lockdiv_frontend
    import lockdiv_pkg::*;
#(
    parameter int unsigned DIV_RATIO   = DEF_DIV_RATIO,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk_fast,
    input  logic clk_ref,
    input  logic rst_n,
    output logic div_clk_o,
    output logic phase_err_o,
    output logic phase_chg_o
);
    logic rst_fast;
    logic rst_ref;
    logic raw_div;

    lockdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_fast (
        .clk    (clk_fast),
        .arst_n (rst_n),
        .rst_o  (rst_fast)
    );

    lockdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_ref (
        .clk    (clk_ref),
        .arst_n (rst_n),
        .rst_o  (rst_ref)
    );

    lockdiv_counter #(.DIV_RATIO(DIV_RATIO)) u_counter (
        .clk   (clk_fast),
        .rst   (rst_fast),
        .raw_o (raw_div)
    );

    // Retimed by the undivided clock: counter delay never reaches the output.
    lockdiv_retime u_retime (
        .clk (clk_fast),
        .rst (rst_fast),
        .d_i (raw_div),
        .q_o (div_clk_o)
    );

    lockdiv_phase_sampler u_sampler (
        .clk   (clk_ref),
        .rst   (rst_ref),
        .d_i   (div_clk_o),
        .err_o (phase_err_o),
        .chg_o (phase_chg_o)
    );
endmodule

// File: rtl/lockdiv_frontend_chk.sv
`timescale 1ns/1ps
module lockdiv_frontend_chk #(
    parameter int unsigned DIV_RATIO = lockdiv_pkg::DEF_DIV_RATIO
) (
    input logic clk_fast,
    input logic clk_ref,
    input logic rst_n,
    input logic div_clk_o,
    input logic phase_err_o,
    input logic phase_chg_o
);
    localparam int unsigned W = $clog2(DIV_RATIO + 2);
    localparam logic [W-1:0] SAT = {W{1'b1}};

    logic         prev_div;
    logic         seen_rise;
    logic [W-1:0] since_rise;
    logic [2:0]   ref_up;

    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            prev_div   <= 1'b0;
            seen_rise  <= 1'b0;
            since_rise <= '0;
        end else begin
            prev_div <= div_clk_o;
            if (div_clk_o && !prev_div) begin
                seen_rise  <= 1'b1;
                since_rise <= W'(1);
            end else if (since_rise != SAT) begin
                since_rise <= since_rise + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_ref) begin
        if (!rst_n)             ref_up <= '0;
        else if (ref_up != 3'd7) ref_up <= ref_up + 3'd1;
    end

    // R3: rising edges one full ratio apart
    assert_div_period_R3: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (div_clk_o && !prev_div && seen_rise) |-> (since_rise == W'(DIV_RATIO)));

    // R4: high time is half the ratio
    assert_div_high_R4: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (!div_clk_o && prev_div && seen_rise) |-> (since_rise == W'(DIV_RATIO / 2)));

    // R5: error bit is the divided level two reference edges earlier
    assert_err_latency_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (ref_up >= 3'd6) |-> (phase_err_o == $past(div_clk_o, 2)));

    // R6: strobe exactly on a change of the error bit
    assert_chg_strobe_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (ref_up >= 3'd3) |-> (phase_chg_o == (phase_err_o != $past(phase_err_o))));
endmodule

bind lockdiv_frontend lockdiv_frontend_chk #(.DIV_RATIO(DIV_RATIO)) u_chk (
    .clk_fast    (clk_fast),
    .clk_ref     (clk_ref),
    .rst_n       (rst_n),
    .div_clk_o   (div_clk_o),
    .phase_err_o (phase_err_o),
    .phase_chg_o (phase_chg_o)
);

// File: tb/lockdiv_frontend_test.sv
`timescale 1ns/1ps
module lockdiv_frontend_test;
    localparam int TB_DIV = 24;
    localparam int HALF   = TB_DIV / 2;
    localparam int FPER   = 4;              // 250 MHz
    localparam int RPER   = TB_DIV * FPER;  // reference at the divided rate
    localparam int RHALF  = RPER / 2;

    logic clk_fast = 1'b0;
    logic clk_ref  = 1'b0;
    logic rst_n    = 1'b0;
    logic div_clk, err, chg;

    int   n_tests  = 0;
    int   n_failed = 0;
    int   ref_adj  = 0;
    time  t_ref    = 0;
    time  t_div    = 0;
    logic have_prev = 1'b0;
    logic prev_exp  = 1'b0;

    typedef struct {
        logic  err;
        logic  chg;
        string req;
    } exp_t;
    exp_t sb_q[$];

    lockdiv_frontend #(.DIV_RATIO(TB_DIV)) uut (
        .clk_fast    (clk_fast),
        .clk_ref     (clk_ref),
        .rst_n       (rst_n),
        .div_clk_o   (div_clk),
        .phase_err_o (err),
        .phase_chg_o (chg)
    );

    initial forever #(FPER / 2) clk_fast = ~clk_fast;

    // Free-running reference; a one-shot stretch of a low phase moves its phase.
    initial begin : ref_gen
        int d;
        #1;
        forever begin
            clk_ref = 1'b1;
            #(RHALF);
            clk_ref = 1'b0;
            d = ref_adj;
            ref_adj = 0;
            #(RHALF + d);
        end
    end

    always @(posedge clk_ref) t_ref = $time;
    always @(posedge div_clk) t_div = $time;

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_failed++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Scoreboard monitor: one expected item per reference cycle.
    initial begin : sb_mon
        exp_t e;
        forever begin
            @(negedge clk_ref);
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                chk(e.req, int'(err), int'(e.err));
                chk("R6", int'(chg), int'(e.chg));
            end
        end
    end

    // R2, R3, R4: release reset and time the divided clock in fast cycles.
    task automatic release_and_measure();
        logic prevv;
        logic cur;
        int   hi;
        int   tot;
        @(negedge clk_fast);
        rst_n = 1'b1;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk_fast);
            chk("R2", int'(div_clk), (k == 3) ? 1 : 0);
        end
        for (int p = 0; p < 3; p++) begin
            hi = 1; tot = 1; prevv = 1'b1;
            while (1) begin
                @(negedge clk_fast);
                cur = div_clk;
                if (cur && !prevv) break;
                tot++;
                if (cur) hi++;
                prevv = cur;
            end
            chk("R3", tot, TB_DIV);
            chk("R4", hi, HALF);
        end
    endtask

    // R5, R6, R7: move the reference to a phase relative to the divided rise.
    task automatic set_phase(input int target);
        int   ph;
        int   adj;
        logic exp_now;
        @(posedge clk_ref);
        #1;
        ph  = ((int'(t_ref) - int'(t_div)) % RPER + RPER) % RPER;
        adj = ((target - ph) % RPER + RPER) % RPER;
        ref_adj = adj;
        exp_now = (target < RHALF);
        @(posedge clk_ref);            // first edge at the new phase
        @(negedge clk_ref);
        if (have_prev) chk("R5", int'(err), int'(prev_exp));
        @(negedge clk_ref);
        chk("R7", int'(err), int'(exp_now));
        if (have_prev) chk("R6", int'(chg), int'(exp_now != prev_exp));
        for (int i = 0; i < 3; i++) sb_q.push_back('{exp_now, 1'b0, "R7"});
        wait (sb_q.size() == 0);
        prev_exp  = exp_now;
        have_prev = 1'b1;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_failed);
        $finish;
    endtask

    initial begin : watchdog
        #(100000 * FPER);
        n_tests++;
        n_failed++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin : main
        repeat (50) @(negedge clk_fast);
        chk("R1", int'(div_clk), 0);
        chk("R1", int'(err), 0);
        chk("R1", int'(chg), 0);
        release_and_measure();

        // Reset in the middle of operation.
        repeat (7) @(negedge clk_fast);
        rst_n = 1'b0;
        @(posedge clk_ref);
        repeat (2) @(negedge clk_fast);
        @(negedge clk_ref);
        chk("R1", int'(div_clk), 0);
        chk("R1", int'(err), 0);
        chk("R1", int'(chg), 0);
        release_and_measure();

        repeat (8) @(negedge clk_ref);
        set_phase(10);   // reference late: 1
        set_phase(42);   // still late, no strobe
        set_phase(58);   // reference early: 0, strobe
        set_phase(90);   // early, no strobe
        set_phase(20);   // late again, strobe
        finish_run();
    end
endmodule